// File: doc/BRIEF.md
# Decade Counter with Snapshot Register

This block pairs a synchronous BCD digit counter with a four-bit snapshot register. The two run on independent clocks. The counter steps 0 through 9 on its own clock. It can be cleared or preset from a four-bit data input, and it advances only when both of its count enables are high. A carry output marks the last digit so that several units can be chained into a multi-digit count.

On each edge of its own clock, the snapshot register copies the live count. It has a separate synchronous clear. A view selector chooses whether the shared output bus shows the live count or the stored snapshot. An active-low output enable either drives that bus or releases it to high impedance, so several units can share one bus. The carry output is always driven.

All state elements also respond to a synchronous active-high reset. Each clock domain samples the reset on its own edge.

Top module: `dcr_decade_unit`

## Requirements
- R1: While `rst` is high, the counter becomes 0 on the next `cnt_clk` rising edge and the snapshot becomes 0 on the next `reg_clk` rising edge.
- R2: With `cnt_clr_n`=1, `load_n`=1, `ena_p`=1 and `ena_t`=1, each `cnt_clk` rising edge adds one to the count, and 9 is followed by 0.
- R3: With `cnt_clr_n`=1 and `load_n`=1, the count keeps its value across a `cnt_clk` edge whenever `ena_p` or `ena_t` is low.
- R4: With `cnt_clr_n`=1 and `load_n`=0, a `cnt_clk` rising edge copies `din` into the counter, whatever the enables are.
- R5: With `cnt_clr_n`=0, a `cnt_clk` rising edge sets the count to 0. This takes precedence over loading and counting.
- R6: When a preset value from 10 to 15 is held and a count step occurs, the count becomes 0.
- R7: `carry_out` is 1 exactly when the count is 9 and `ena_t` is 1. It does not depend on `ena_p`.
- R8: With `reg_clr_n`=1, a `reg_clk` rising edge stores the live count in the snapshot register. The snapshot does not change between `reg_clk` edges.
- R9: With `reg_clr_n`=0, a `reg_clk` rising edge sets the snapshot to 0.
- R10: With `oe_n`=0, `q` shows the live count when `show_reg`=0 and the snapshot when `show_reg`=1. Bit 0 of `q` is the least significant bit.
- R11: With `oe_n`=1, all four bits of `q` are high impedance. `carry_out` keeps being driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cnt_clk | input | 1 | Counter clock, rising edge |
| reg_clk | input | 1 | Snapshot register clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, sampled in both clock domains |
| cnt_clr_n | input | 1 | Active-low synchronous counter clear |
| load_n | input | 1 | Active-low synchronous preset from `din` |
| ena_p | input | 1 | Count enable; does not affect the carry |
| ena_t | input | 1 | Count enable that also qualifies the carry |
| din | input | 4 | Preset value |
| reg_clr_n | input | 1 | Active-low synchronous snapshot clear |
| show_reg | input | 1 | 0 selects the live count, 1 selects the snapshot |
| oe_n | input | 1 | Active-low output enable for `q` |
| q | output | 4 | Three-state output bus |
| carry_out | output | 1 | Carry for cascading, always driven |

## Verification
The bench targets the following corner cases:
- The wrap from 9 to 0. A counter that wraps at 16 would show 10 instead.
- Presets of 10 to 15 followed by a step. A design that only tests equality with 9 would go on to 11 or beyond.
- A clear and a load in the same cycle. A wrong priority would leave the preset value in the counter.
- A count of 9 with `ena_p` low and `ena_t` high. A carry gated by both enables would stay low here.
- The view selector and output enable during random sequences, including snapshots taken just after the counter has moved. A swapped selector, or a `q` that is not released, shows up directly on the bus.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_STEP  = 2'd1,
    CNT_LOAD  = 2'd2,
    CNT_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/dcr_counter.sv
module dcr_counter
  import dcr_pkg::*;
#(
  parameter int MODULUS = 10,
  parameter int W       = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] din,
  output logic [W-1:0] cnt,
  output logic         carry
);
  localparam logic [W-1:0] LAST = W'(MODULUS - 1);

  cnt_op_e      op;
  logic [W-1:0] nxt;

  // priority: clear, then load, then count
  always_comb begin
    if (!clr_n)             op = CNT_CLEAR;
    else if (!load_n)       op = CNT_LOAD;
    else if (en_p && en_t)  op = CNT_STEP;
    else                    op = CNT_HOLD;
  end

  always_comb begin
    case (op)
      CNT_CLEAR: nxt = '0;
      CNT_LOAD:  nxt = din;
      CNT_STEP:  nxt = (cnt >= LAST) ? '0 : cnt + 1'b1;
      default:   nxt = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= nxt;
  end

  assign carry = (cnt == LAST) && en_t;

  // R5
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> cnt == '0);
  // R4
  cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !load_n) |=> cnt == $past(din));
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && en_p && en_t && cnt < LAST) |=> cnt == W'($past(cnt) + 1'b1));
  // R6
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && en_p && en_t && cnt >= LAST) |=> cnt == '0);
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && !(en_p && en_t)) |=> $stable(cnt));
endmodule

// File: rtl/dcr_hold_reg.sv
module dcr_hold_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || !clr_n) q <= '0;
    else               q <= d;
  end

  // R9
  snap_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> q == '0);
  // R8
  snap_capture_chk: assert property (@(posedge clk) disable iff (rst)
    clr_n |=> q == $past(d));
endmodule

// File: rtl/dcr_out_sel.sv
module dcr_out_sel #(
  parameter int W = 4
) (
  input  logic         sel,
  input  logic         oe_n,
  input  logic [W-1:0] live,
  input  logic [W-1:0] snap,
  output logic [W-1:0] bus
);
  logic [W-1:0] chosen;

  assign chosen = sel ? snap : live;
  assign bus    = oe_n ? {W{1'bz}} : chosen;
endmodule

// File: rtl/dcr_decade_unit.sv
module dcr_decade_unit #(
  parameter int MODULUS = 10,
  localparam int W = $clog2(MODULUS)
) (
  input  logic         cnt_clk,
  input  logic         reg_clk,
  input  logic         rst,
  input  logic         cnt_clr_n,
  input  logic         load_n,
  input  logic         ena_p,
  input  logic         ena_t,
  input  logic [W-1:0] din,
  input  logic         reg_clr_n,
  input  logic         show_reg,
  input  logic         oe_n,
  output logic [W-1:0] q,
  output logic         carry_out
);
  logic [W-1:0] live_cnt;
  logic [W-1:0] snap_val;

  dcr_counter #(.MODULUS(MODULUS), .W(W)) u_counter (
    .clk(cnt_clk), .rst(rst), .clr_n(cnt_clr_n), .load_n(load_n),
    .en_p(ena_p), .en_t(ena_t), .din(din), .cnt(live_cnt), .carry(carry_out)
  );

  dcr_hold_reg #(.W(W)) u_snap (
    .clk(reg_clk), .rst(rst), .clr_n(reg_clr_n), .d(live_cnt), .q(snap_val)
  );

  dcr_out_sel #(.W(W)) u_sel (
    .sel(show_reg), .oe_n(oe_n), .live(live_cnt), .snap(snap_val), .bus(q)
  );
endmodule

// File: tb/dcr_decade_unit_tb.sv
module dcr_decade_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic cnt_clk = 0, reg_clk = 0, rst = 1;
  logic cnt_clr_n = 1, load_n = 1, ena_p = 0, ena_t = 0;
  logic [3:0] din = '0;
  logic reg_clr_n = 1, show_reg = 0, oe_n = 0;
  logic [3:0] q;
  logic carry_out;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [3:0] exp_cnt = '0, exp_reg = '0;

  dcr_decade_unit u_dut (
    .cnt_clk(cnt_clk), .reg_clk(reg_clk), .rst(rst), .cnt_clr_n(cnt_clr_n),
    .load_n(load_n), .ena_p(ena_p), .ena_t(ena_t), .din(din),
    .reg_clr_n(reg_clr_n), .show_reg(show_reg), .oe_n(oe_n),
    .q(q), .carry_out(carry_out)
  );

  always #(CLK_PERIOD/2) cnt_clk = ~cnt_clk;

  function automatic logic [3:0] next_cnt(logic c, logic l, logic p, logic t,
                                          logic [3:0] d, logic [3:0] cur);
    if (!c)          return 4'd0;
    else if (!l)     return d;
    else if (p && t) return (cur >= 4'd9) ? 4'd0 : cur + 4'd1;
    else             return cur;
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one counter cycle, then check live view and carry
  task automatic cyc(logic c, logic l, logic p, logic t, logic [3:0] d, string tag);
    @(negedge cnt_clk);
    cnt_clr_n = c; load_n = l; ena_p = p; ena_t = t; din = d;
    @(posedge cnt_clk);
    if (rst) exp_cnt = 4'd0;
    else     exp_cnt = next_cnt(c, l, p, t, d, exp_cnt);
    #2;
    show_reg = 0; oe_n = 0;
    #1;
    check({tag, " live"}, q, exp_cnt);
    check({"R7 carry ", tag}, {3'b0, carry_out}, {3'b0, (exp_cnt == 4'd9) && t});
    cnt_clr_n = 1; load_n = 1; ena_p = 0;
  endtask

  task automatic snap(logic rc, string tag);
    @(negedge cnt_clk);
    reg_clr_n = rc;
    #1 reg_clk = 1;
    exp_reg = (rst || !rc) ? 4'd0 : exp_cnt;
    #1 reg_clk = 0;
    show_reg = 1; oe_n = 0;
    #1;
    check({tag, " R10 snapshot view"}, q, exp_reg);
    show_reg = 0;
    reg_clr_n = 1;
  endtask

  task automatic check_hiz(string tag);
    @(negedge cnt_clk);
    oe_n = 1;
    #1;
    check({"R11 hi-z ", tag}, q, 4'bzzzz);
    checks++;
    if (carry_out !== ((exp_cnt == 4'd9) && ena_t)) begin
      errors++;
      $display("FAIL R11 carry driven actual=%b expected=%b", carry_out,
               (exp_cnt == 4'd9) && ena_t);
    end
    oe_n = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: reset clears both stores
    rst = 1;
    cyc(1, 0, 1, 1, 4'd6, "R1 reset counter");
    snap(1, "R1 reset snapshot");
    rst = 0;
    // R2 counting and wrap
    cyc(1, 0, 0, 0, 4'd7, "R4 load 7");
    cyc(1, 1, 1, 1, 4'd0, "R2 step to 8");
    cyc(1, 1, 1, 1, 4'd0, "R2 step to 9");
    cyc(1, 1, 1, 1, 4'd0, "R2 wrap 9 to 0");
    // R7 carry with ena_p low
    cyc(1, 0, 0, 1, 4'd9, "R4 load 9");
    cyc(1, 1, 0, 1, 4'd0, "R3 R7 hold at 9 ena_p low");
    cyc(1, 1, 1, 0, 4'd0, "R3 R7 hold at 9 ena_t low");
    // R6 illegal presets
    for (int v = 10; v < 16; v++) begin
      cyc(1, 0, 1, 1, 4'(v), "R6 preset high");
      cyc(1, 1, 1, 1, 4'd0, "R6 step from high");
    end
    // R5 clear beats load
    cyc(1, 0, 0, 0, 4'd5, "R4 load 5");
    cyc(0, 0, 1, 1, 4'd3, "R5 clear over load");
    // R8 / R9 snapshot
    cyc(1, 0, 0, 0, 4'd4, "R4 load 4");
    snap(1, "R8 capture 4");
    cyc(1, 1, 1, 1, 4'd0, "R2 step to 5");
    snap(0, "R9 snapshot clear");
    check_hiz("directed");
    // R1 mid-run reset
    cyc(1, 0, 0, 0, 4'd8, "R4 load 8");
    snap(1, "R8 capture 8");
    rst = 1;
    cyc(1, 1, 1, 1, 4'd0, "R1 mid reset counter");
    snap(1, "R1 mid reset snapshot");
    rst = 0;
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic c, l, p, t;
      logic [3:0] d;
      c = ($urandom % 16) != 0;
      l = ($urandom % 6) != 0;
      p = ($urandom % 4) != 0;
      t = ($urandom % 4) != 0;
      d = 4'($urandom % 16);
      cyc(c, l, p, t, d, "R2 R3 R4 R5 random");
      if (i % 3 == 0) snap(($urandom % 8) != 0, "R8 R9 random");
      if (i % 7 == 0) check_hiz("random");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule